// File: doc/BRIEF.md
# MIDI UART-Mode Host Port with Dual FIFOs

This block gives a host processor a two-offset byte port onto a MIDI serial link, in the manner of a classic UART-mode MIDI interface. Offset 0 carries data. A write queues a byte for transmission, and a read takes the oldest received byte. Offset 1 is split by direction. A read returns a status byte with two active-low ready flags. A write issues a command. Each direction has its own 16-entry byte FIFO, so the transmitter and the receiver work at the same time and independently.

Outgoing bytes are serialised as 8N1 frames on `midi_out`. Incoming frames on `midi_in` are deserialised into the receive FIFO. The bit time is the system clock divided by the ratio of `CLK_HZ` to `BAUD`, and the default is 31250 baud. Two commands are recognised: a port reset and an enter-UART request. Each places an acknowledge byte in the receive stream. A level output stays high for as long as received data waits to be read.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, the status byte reads 0xBF, `rx_irq` is 0 and `midi_out` idles high.
- R2: The status byte at offset 1 has the following bits:
  - bit 7 is 0 exactly when the receive FIFO holds data.
  - bit 6 is 0 exactly when the transmit FIFO has a free entry.
  - bits 5..0 always read 1.
- R3: Each byte written at offset 0 goes out on `midi_out` as an 8N1 frame, in write order:
  - one low start bit, then eight data bits with the LSB first, then one high stop bit.
  - each bit lasts CLK_HZ/BAUD clock cycles.
- R4: The transmit FIFO holds 16 bytes, and one more byte can sit in the serialiser. A data write made while the FIFO is full is dropped.
- R5: A valid 8N1 frame on `midi_in` places its byte in the receive FIFO. Reads at offset 0 return the received bytes in arrival order.
- R6: The receive FIFO holds 16 bytes. A byte that completes while it is full is discarded.
- R7: A data read while the receive FIFO is empty returns the byte most recently read, and it leaves the FIFO state unchanged.
- R8: Command 0xFF empties both FIFOs and then places the acknowledge byte 0xFE in the receive FIFO. A byte already in the serialiser still completes.
- R9: Command 0x3F places 0xFE in the receive FIFO. Any other command value has no effect.
- R10: `rx_irq` is high exactly while the receive FIFO is not empty.
- R11: Transmission and reception overlap without loss or reordering in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data port, 1 = status/command port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid during the access cycle |
| midi_in | input | 1 | Serial MIDI input, idle high |
| midi_out | output | 1 | Serial MIDI output, idle high |
| rx_irq | output | 1 | High while received data is pending |

## Verification
The assertions assume the following about the host interface:
- every host access lasts one clock with `bus_sel` high.
- a command write never coincides with a data write.
- frames on `midi_in` meet the configured bit time.

The stimulus meets these assumptions by construction:
- every bus access goes through tasks that raise `bus_sel` for exactly one cycle and then leave one idle cycle.
- the serial driver produces whole frames at exactly the divider rate.
- random choices are limited to byte values and burst lengths.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;
   localparam logic [7:0] CMD_PORT_RESET = 8'hFF;
   localparam logic [7:0] CMD_ENTER_UART = 8'h3F;
   localparam logic [7:0] ACK_CODE       = 8'hFE;
   localparam int         STAT_RX_BIT    = 7;
   localparam int         STAT_TX_BIT    = 6;

   typedef enum logic [1:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_STOP
   } rx_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2) begin : g_depth_chk
      $error("byte_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_idx, wr_idx, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign dout    = mem[rd_idx];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (POW2) begin : g_pow2
      assign rd_nxt = rd_idx + 1'b1;
      assign wr_nxt = wr_idx + 1'b1;
   end else begin : g_wrap
      assign rd_nxt = (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
      assign wr_nxt = (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx <= '0;
         wr_idx <= '0;
         cnt    <= '0;
      end else if (clear) begin
         rd_idx <= '0;
         wr_idx <= push ? AW'(1) : '0;
         cnt    <= push ? CW'(1) : '0;
      end else begin
         if (do_push) wr_idx <= wr_nxt;
         if (do_pop)  rd_idx <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (clear && push)         mem[0]      <= din;
      else if (!clear && do_push) mem[wr_idx] <= din;
   end

   // R4
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clear) |=> (full && $stable(wr_idx)));

   // R8
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !push) |=> empty);

   // R8
   clear_push_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && push) |=> (!empty && !full));
endmodule

// File: rtl/midi_tx.sv
module midi_tx #(
   parameter int DIV = 1600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] data,
   output logic       busy,
   output logic       line
);
   localparam int CNTW = $clog2(DIV);

   logic [9:0]      frame;
   logic [3:0]      bit_no;
   logic [CNTW-1:0] tick;

   assign line = frame[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame  <= '1;
         bit_no <= '0;
         tick   <= '0;
         busy   <= 1'b0;
      end else if (load && !busy) begin
         frame  <= {1'b1, data, 1'b0};
         bit_no <= '0;
         tick   <= '0;
         busy   <= 1'b1;
      end else if (busy) begin
         if (tick == CNTW'(DIV - 1)) begin
            tick  <= '0;
            frame <= {1'b1, frame[9:1]};
            if (bit_no == 4'd9) busy <= 1'b0;
            else                bit_no <= bit_no + 1'b1;
         end else begin
            tick <= tick + 1'b1;
         end
      end
   end

   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line);

   // R3
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line);
endmodule

// File: rtl/midi_rx.sv
module midi_rx
   import midi_uart_pkg::*;
#(
   parameter int DIV = 1600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line,
   output logic       valid,
   output logic [7:0] data
);
   localparam int CNTW = $clog2(DIV);
   localparam int HALF = DIV / 2;

   logic [1:0]      sync;
   logic            rx_s;
   rx_state_t       state;
   logic [CNTW-1:0] tick;
   logic [2:0]      bit_no;
   logic [7:0]      shreg;

   assign rx_s = sync[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync   <= 2'b11;
         state  <= RXS_IDLE;
         tick   <= '0;
         bit_no <= '0;
         shreg  <= '0;
         data   <= '0;
         valid  <= 1'b0;
      end else begin
         sync  <= {sync[0], line};
         valid <= 1'b0;
         case (state)
            RXS_IDLE: begin
               tick <= '0;
               if (!rx_s) state <= RXS_START;
            end
            RXS_START: begin
               if (tick == CNTW'(HALF - 1)) begin
                  tick   <= '0;
                  bit_no <= '0;
                  state  <= rx_s ? RXS_IDLE : RXS_DATA;
               end else begin
                  tick <= tick + 1'b1;
               end
            end
            RXS_DATA: begin
               if (tick == CNTW'(DIV - 1)) begin
                  tick  <= '0;
                  shreg <= {rx_s, shreg[7:1]};
                  if (bit_no == 3'd7) state <= RXS_STOP;
                  else                bit_no <= bit_no + 1'b1;
               end else begin
                  tick <= tick + 1'b1;
               end
            end
            default: begin
               if (tick == CNTW'(DIV - 1)) begin
                  tick  <= '0;
                  state <= RXS_IDLE;
                  valid <= rx_s;
                  data  <= shreg;
               end else begin
                  tick <= tick + 1'b1;
               end
            end
         endcase
      end
   end

   // R5
   valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($past(state) == RXS_STOP && state == RXS_IDLE));
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
   import midi_uart_pkg::*;
#(
   parameter int CLK_HZ = 50_000_000,
   parameter int BAUD   = 31_250,
   parameter int DEPTH  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       midi_in,
   output logic       midi_out,
   output logic       rx_irq
);
   localparam int DIV = CLK_HZ / BAUD;

   if (DIV < 4) begin : g_div_chk
      $error("midi_uart_port: CLK_HZ/BAUD must be at least 4");
   end

   logic       data_wr, data_rd, cmd_wr, is_reset, is_ack;
   logic       tx_empty, tx_full, tx_busy, tx_go;
   logic [7:0] tx_dout;
   logic       rx_empty, rx_full, rx_push;
   logic [7:0] rx_dout, rx_din;
   logic       des_valid;
   logic [7:0] des_data;
   logic       hold_v;
   logic [7:0] hold_b, last_rd;
   logic [7:0] status;

   assign data_wr  = bus_sel &&  bus_wr && !bus_addr;
   assign data_rd  = bus_sel && !bus_wr && !bus_addr;
   assign cmd_wr   = bus_sel &&  bus_wr &&  bus_addr;
   assign is_reset = cmd_wr && (bus_wdata == CMD_PORT_RESET);
   assign is_ack   = is_reset || (cmd_wr && bus_wdata == CMD_ENTER_UART);

   // transmit path
   assign tx_go = !tx_busy && !tx_empty && !is_reset;

   byte_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clear(is_reset),
      .push(data_wr), .din(bus_wdata), .pop(tx_go),
      .dout(tx_dout), .empty(tx_empty), .full(tx_full)
   );

   midi_tx #(.DIV(DIV)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(tx_go), .data(tx_dout),
      .busy(tx_busy), .line(midi_out)
   );

   // receive path: deserialised byte waits in a holding slot when an ack
   // claims the FIFO write port in the same cycle
   midi_rx #(.DIV(DIV)) u_des (
      .clk(clk), .rst_n(rst_n), .line(midi_in),
      .valid(des_valid), .data(des_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_b <= '0;
      end else if (des_valid) begin
         hold_v <= 1'b1;
         hold_b <= des_data;
      end else if (!is_ack) begin
         hold_v <= 1'b0;
      end
   end

   assign rx_push = is_ack || hold_v;
   assign rx_din  = is_ack ? ACK_CODE : hold_b;

   byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clear(is_reset),
      .push(rx_push), .din(rx_din), .pop(data_rd),
      .dout(rx_dout), .empty(rx_empty), .full(rx_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     last_rd <= '0;
      else if (data_rd && !rx_empty)  last_rd <= rx_dout;
   end

   always_comb begin
      status              = 8'hFF;
      status[STAT_RX_BIT] = rx_empty;
      status[STAT_TX_BIT] = tx_full;
   end

   assign bus_rdata = bus_addr ? status : (rx_empty ? last_rd : rx_dout);
   assign rx_irq    = !rx_empty;

   // R8
   reset_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> (!rx_empty && tx_empty));

   // R9
   uart_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata == CMD_ENTER_UART && !rx_full) |=> !rx_empty);

   // R7
   empty_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && rx_empty && !rx_push) |=> ($stable(last_rd) && rx_empty));
endmodule

// File: tb/midi_uart_port_bench.sv
module midi_uart_port_bench;
   localparam int CLK_HZ = 50_000_000;
   localparam int BAUD   = 3_125_000;
   localparam int DIV    = CLK_HZ / BAUD;
   localparam int DEPTH  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       midi_in = 1'b1;
   logic       midi_out, rx_irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] mon_q[$];
   logic [7:0] exp_tx[$];
   int stop_errs = 0;

   midi_uart_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH)) u_midi_uart_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .midi_in(midi_in), .midi_out(midi_out), .rx_irq(rx_irq)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] exp_status(input bit rx_has, input bit tx_full);
      return {~rx_has, tx_full, 6'b111111};
   endfunction

   task automatic check(input bit ok, input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic midi_send(input logic [7:0] b);
      @(negedge clk);
      midi_in = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         midi_in = b[i];
         repeat (DIV) @(negedge clk);
      end
      midi_in = 1'b1;
      repeat (DIV) @(negedge clk);
   endtask

   task automatic wait_tx(input int n);
      repeat (n * (10 * DIV + 4) + 40) @(negedge clk);
   endtask

   task automatic compare_tx(input string req);
      check(mon_q.size() == exp_tx.size(), req, 8'(mon_q.size()), 8'(exp_tx.size()));
      for (int i = 0; i < exp_tx.size() && i < mon_q.size(); i++)
         check(mon_q[i] === exp_tx[i], req, mon_q[i], exp_tx[i]);
      mon_q.delete();
      exp_tx.delete();
   endtask

   // serial monitor on midi_out
   initial begin
      forever begin
         logic [7:0] b;
         @(negedge midi_out);
         repeat (DIV / 2) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(negedge clk);
            b[i] = midi_out;
         end
         repeat (DIV) @(negedge clk);
         if (midi_out !== 1'b1) stop_errs++;
         mon_q.push_back(b);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] rxb[$];
      int seed_init;
      seed_init = $urandom(32'h5EED_0724);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      bus_read(1'b1, d);
      check(d === 8'hBF, "R1 status", d, 8'hBF);
      check(rx_irq === 1'b0, "R1 irq", {7'b0, rx_irq}, 8'h00);
      check(midi_out === 1'b1, "R1 line idle", {7'b0, midi_out}, 8'h01);

      // R3 directed plus random bytes
      for (int i = 0; i < 3; i++) begin
         d = (i == 0) ? 8'h80 : 8'($urandom);
         exp_tx.push_back(d);
         bus_write(1'b0, d);
      end
      wait_tx(3);
      compare_tx("R3 tx frames");

      // R4 fill transmit path, extra writes dropped
      for (int i = 0; i < 20; i++) begin
         d = 8'($urandom);
         if (i < DEPTH + 1) exp_tx.push_back(d);
         bus_write(1'b0, d);
         if (i == DEPTH - 1) begin
            bus_read(1'b1, d);
            check(d === exp_status(0, 0), "R4 not full at 16 writes", d, exp_status(0, 0));
         end
         if (i == DEPTH) begin
            bus_read(1'b1, d);
            check(d === exp_status(0, 1), "R2 R4 full flag", d, exp_status(0, 1));
         end
      end
      wait_tx(DEPTH + 1);
      compare_tx("R4 drop when full");

      // R5 R10 R11 full duplex
      rxb.delete();
      for (int i = 0; i < 4; i++) rxb.push_back(8'($urandom));
      fork
         for (int i = 0; i < 4; i++) midi_send(rxb[i]);
         for (int i = 0; i < 4; i++) begin
            logic [7:0] t;
            t = 8'($urandom);
            exp_tx.push_back(t);
            bus_write(1'b0, t);
         end
      join
      repeat (10) @(negedge clk);
      check(rx_irq === 1'b1, "R10 irq pending", {7'b0, rx_irq}, 8'h01);
      bus_read(1'b1, d);
      check(d === exp_status(1, 0), "R2 rx ready", d, exp_status(1, 0));
      for (int i = 0; i < 4; i++) begin
         bus_read(1'b0, d);
         check(d === rxb[i], "R5 R11 rx order", d, rxb[i]);
      end
      check(rx_irq === 1'b0, "R10 irq clear", {7'b0, rx_irq}, 8'h00);
      wait_tx(4);
      compare_tx("R11 tx during rx");

      // R6 overflow of receive FIFO
      rxb.delete();
      for (int i = 0; i < DEPTH + 2; i++) begin
         rxb.push_back(8'($urandom));
         midi_send(rxb[i]);
      end
      repeat (10) @(negedge clk);
      for (int i = 0; i < DEPTH; i++) begin
         bus_read(1'b0, d);
         check(d === rxb[i], "R6 kept bytes", d, rxb[i]);
      end
      bus_read(1'b1, d);
      check(d === exp_status(0, 0), "R6 extra bytes discarded", d, exp_status(0, 0));

      // R7 empty read repeats last byte
      bus_read(1'b0, d);
      check(d === rxb[DEPTH - 1], "R7 empty read", d, rxb[DEPTH - 1]);
      bus_read(1'b0, d);
      check(d === rxb[DEPTH - 1], "R7 empty read again", d, rxb[DEPTH - 1]);
      bus_read(1'b1, d);
      check(d === exp_status(0, 0), "R7 still empty", d, exp_status(0, 0));

      // R8 port reset clears both FIFOs
      midi_send(8'h11);
      midi_send(8'h22);
      repeat (10) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         d = 8'(8'h40 + i);
         if (i == 0) exp_tx.push_back(d);
         bus_write(1'b0, d);
      end
      bus_write(1'b1, 8'hFF);
      bus_read(1'b0, d);
      check(d === 8'hFE, "R8 ack byte", d, 8'hFE);
      bus_read(1'b1, d);
      check(d === exp_status(0, 0), "R8 fifos emptied", d, exp_status(0, 0));
      wait_tx(5);
      compare_tx("R8 tx cleared");

      // R9 enter-UART ack, other commands ignored
      bus_write(1'b1, 8'h3F);
      bus_read(1'b1, d);
      check(d === exp_status(1, 0), "R9 ack pending", d, exp_status(1, 0));
      bus_read(1'b0, d);
      check(d === 8'hFE, "R9 ack byte", d, 8'hFE);
      bus_write(1'b1, 8'h12);
      bus_read(1'b1, d);
      check(d === exp_status(0, 0), "R9 other command ignored", d, exp_status(0, 0));
      check(rx_irq === 1'b0, "R9 R10 no irq", {7'b0, rx_irq}, 8'h00);

      // random full-duplex rounds
      for (int r = 0; r < 6; r++) begin
         int n;
         n = 1 + int'($urandom % 4);
         rxb.delete();
         for (int i = 0; i < n; i++) rxb.push_back(8'($urandom));
         fork
            for (int i = 0; i < n; i++) midi_send(rxb[i]);
            for (int i = 0; i < n; i++) begin
               logic [7:0] t;
               t = 8'($urandom);
               exp_tx.push_back(t);
               bus_write(1'b0, t);
            end
         join
         repeat (10) @(negedge clk);
         for (int i = 0; i < n; i++) begin
            bus_read(1'b0, d);
            check(d === rxb[i], "R5 random rx", d, rxb[i]);
         end
         wait_tx(n);
         compare_tx("R3 random tx");
      end

      check(stop_errs == 0, "R3 stop bits", 8'(stop_errs), 8'h00);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule